// File: doc/BRIEF.md
# Multicycle RISC Datapath

This block is the storage and arithmetic half of a 32-bit multicycle processor for a simple load/store instruction set. It holds the program counter, an instruction register, a memory data register, two operand latches (A and B), an ALU result register, a 32-entry register file, an ALU and a small unified word memory. It also holds every selector that routes operands, addresses and the next program counter. It makes no decisions of its own. An external sequencer drives one strobe per control line on every clock. The block returns the opcode and function fields of the held instruction and a combinational zero flag, which the sequencer uses to pick its next step.

A typical instruction takes several clocks. The first clock fetches and advances the PC. The next decodes, while A and B pick up the source registers and the ALU forms a branch target. Later clocks execute, access memory and write back. The program counter and the ALU result register are exported as well, so a sequencer or a test harness can follow the flow of control. On reset the memory is filled with a fixed computed image. This gives the datapath a program to fetch with no loading interface.

Top module: `mcdp_top`

## Requirements
- R1: Reset (active-low `rstN`, asynchronous) clears PC, instruction register, data register, A, B, ALU result register and all 32 registers. Memory word k is set to {k[5:0] opcode, rs=(k+16) mod 32, rt=(k+1) mod 32, rd=(k+17) mod 32, bits 10:6 zero, funct from the cycle 0x20,0x22,0x24,0x25,0x2A,0x3F indexed by k mod 6}.
- R2: The register write address is instruction bits 15:11 when `regDst`=1 and bits 20:16 when `regDst`=0.
- R3: When `regWrite`=1 the addressed register takes the write data at the clock edge. Register 0 always reads zero, and writes to it are ignored.
- R4: Write data is the data register when `memToReg`=1 and the ALU result register when `memToReg`=0.
- R5: The first ALU operand is A when `aluSrcA`=1 and the PC when it is 0. `aluSrcB` selects the second operand: 00 gives B, 01 gives 4, 10 gives sign-extended IR[15:0], and 11 gives that value shifted left by 2.
- R6: `aluOp` 00 and 11 add, and 01 subtracts. 10 decodes IR[5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than giving 1 or 0. Every other code gives a zero result.
- R7: `zero` is 1 in the same cycle exactly when the live ALU result is zero.
- R8: The memory byte address is the ALU result register when `iOrD`=1 and the PC otherwise. Bits [7:2] select the word with the default 64-word depth. `memRead` loads the addressed word into the data register. `irWrite` loads it into the instruction register, and `opcode`=IR[31:26] and `funct`=IR[5:0] then follow.
- R9: `memWrite` replaces the addressed word with B at the clock edge.
- R10: The PC loads when `pcWrite`=1, or when `pcWriteCond`=1 and `zero`=1. Otherwise it holds.
- R11: `pcSource` selects the next PC: 00 and 11 give the live ALU result, 01 gives the ALU result register, and 10 gives {PC[31:28], IR[25:0], 2'b00}.
- R12: A takes register IR[25:21], B takes register IR[20:16], and the ALU result register takes the live ALU result on every clock edge. The registers are read before that edge's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regDst | input | 1 | Write address from rd (1) or rt (0) |
| regWrite | input | 1 | Register file write strobe |
| aluSrcA | input | 1 | First operand A (1) or PC (0) |
| aluSrcB | input | 2 | Second operand select |
| aluOp | input | 2 | ALU operation class |
| memRead | input | 1 | Load data register from memory |
| memWrite | input | 1 | Write B into memory |
| memToReg | input | 1 | Write data from data register (1) or ALU result register (0) |
| iOrD | input | 1 | Memory address from ALU result register (1) or PC (0) |
| irWrite | input | 1 | Load instruction register from memory |
| pcWrite | input | 1 | Unconditional PC load |
| pcWriteCond | input | 1 | PC load when zero is set |
| pcSource | input | 2 | Next PC select |
| opcode | output | 6 | IR[31:26] |
| funct | output | 6 | IR[5:0] |
| zero | output | 1 | Live ALU result is zero |
| pcOut | output | 32 | Current PC |
| aluOutQ | output | 32 | ALU result register |

## Verification
A wrong value in A, B, the data register or a register-file entry stays hidden until a later clock routes it through the ALU. The fault then appears on `aluOutQ` one edge after that clock and on `zero` within the same clock, so stimulus sequences write a register, read it back through A or B, and compute with it. A wrong instruction or memory word shows on `opcode`/`funct` one edge after the fetch, and a wrong next-PC choice shows on `pcOut` one edge after the load. A cycle-level model in the bench follows every strobe and compares these outputs on every clock.

// File: rtl/mcdp_pkg.sv
`timescale 1ns/1ps
package mcdp_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned RF_DEPTH = 32;

  localparam logic [5:0] FCODE_ADD = 6'h20;
  localparam logic [5:0] FCODE_SUB = 6'h22;
  localparam logic [5:0] FCODE_AND = 6'h24;
  localparam logic [5:0] FCODE_OR  = 6'h25;
  localparam logic [5:0] FCODE_SLT = 6'h2A;
  localparam logic [5:0] FCODE_NOP = 6'h3F;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_SLT  = 3'd4,
    ALU_NULL = 3'd5
  } aluFn_e;

  // strobes handed from the control decode to the datapath
  typedef struct packed {
    logic       regDst;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    aluFn_e     aluFn;
    logic       memRead;
    logic       memWrite;
    logic       memToReg;
    logic       iOrD;
    logic       irWrite;
    logic       pcWrite;
    logic       pcWriteCond;
    logic [1:0] pcSource;
  } strobes_t;

  // computed memory image loaded at reset
  function automatic logic [31:0] bootWord(input int unsigned k);
    logic [5:0] fc;
    case (k % 6)
      0:       fc = FCODE_ADD;
      1:       fc = FCODE_SUB;
      2:       fc = FCODE_AND;
      3:       fc = FCODE_OR;
      4:       fc = FCODE_SLT;
      default: fc = FCODE_NOP;
    endcase
    return {6'(k), 5'(k + 16), 5'(k + 1), 5'(k + 17), 5'd0, fc};
  endfunction
endpackage

// File: rtl/mcdp_alu.sv
`timescale 1ns/1ps
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int unsigned WIDTH = XLEN
) (
  input  aluFn_e           fn,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             isZero
);
  logic lessThan;
  assign lessThan = $signed(opA) < $signed(opB);

  always_comb begin
    case (fn)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(WIDTH-1){1'b0}}, lessThan};
      default: result = '0;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/mcdp_regfile.sv
`timescale 1ns/1ps
module mcdp_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  output logic [WIDTH-1:0] rdDataA,
  output logic [WIDTH-1:0] rdDataB
);
  logic [WIDTH-1:0] regs [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(DEPTH); i++) regs[i] <= '0;
    end else if (wrEn && (wrIdx != '0)) begin
      regs[wrIdx] <= wrData;
    end
  end

  assign rdDataA = (rdIdxA == '0) ? '0 : regs[rdIdxA];
  assign rdDataB = (rdIdxB == '0) ? '0 : regs[rdIdxB];
endmodule

// File: rtl/mcdp_memory.sv
`timescale 1ns/1ps
module mcdp_memory
  import mcdp_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned WORDS = 64,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wordIdx,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] cells [WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int unsigned k = 0; k < WORDS; k++) cells[k] <= WIDTH'(bootWord(k));
    end else if (wrEn) begin
      cells[wordIdx] <= wrData;
    end
  end

  assign rdData = cells[wordIdx];
endmodule

// File: rtl/mcdp_ctrl.sv
`timescale 1ns/1ps
module mcdp_ctrl
  import mcdp_pkg::*;
(
  input  logic       regDst,
  input  logic       regWrite,
  input  logic       aluSrcA,
  input  logic [1:0] aluSrcB,
  input  logic [1:0] aluOp,
  input  logic       memRead,
  input  logic       memWrite,
  input  logic       memToReg,
  input  logic       iOrD,
  input  logic       irWrite,
  input  logic       pcWrite,
  input  logic       pcWriteCond,
  input  logic [1:0] pcSource,
  input  logic [5:0] functField,
  output strobes_t   strobes
);
  aluFn_e decodedFn;

  always_comb begin
    case (functField)
      FCODE_ADD: decodedFn = ALU_ADD;
      FCODE_SUB: decodedFn = ALU_SUB;
      FCODE_AND: decodedFn = ALU_AND;
      FCODE_OR:  decodedFn = ALU_OR;
      FCODE_SLT: decodedFn = ALU_SLT;
      default:   decodedFn = ALU_NULL;
    endcase
  end

  always_comb begin
    strobes.regDst      = regDst;
    strobes.regWrite    = regWrite;
    strobes.aluSrcA     = aluSrcA;
    strobes.aluSrcB     = aluSrcB;
    strobes.memRead     = memRead;
    strobes.memWrite    = memWrite;
    strobes.memToReg    = memToReg;
    strobes.iOrD        = iOrD;
    strobes.irWrite     = irWrite;
    strobes.pcWrite     = pcWrite;
    strobes.pcWriteCond = pcWriteCond;
    strobes.pcSource    = pcSource;
    case (aluOp)
      2'b01:   strobes.aluFn = ALU_SUB;
      2'b10:   strobes.aluFn = decodedFn;
      default: strobes.aluFn = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcdp_datapath.sv
`timescale 1ns/1ps
module mcdp_datapath
  import mcdp_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobes_t        strobes,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            zero,
  output logic [XLEN-1:0] pcOut,
  output logic [XLEN-1:0] aluOutQ
);
  localparam int unsigned MEM_IDX_W = $clog2(MEM_WORDS);
  localparam int unsigned RF_IDX_W  = $clog2(RF_DEPTH);
  localparam int unsigned IMM_W     = 16;

  logic [XLEN-1:0] pcQ, irQ, mdrQ, aQ, bQ, aluOutR;
  logic [XLEN-1:0] rfA, rfB, rfWrData, immExt, opA, opB;
  logic [XLEN-1:0] aluRes, memAddr, memRdData, jumpTarget, nextPc;
  logic [RF_IDX_W-1:0] rsIdx, rtIdx, rdIdx, rfWrIdx;
  logic [MEM_IDX_W-1:0] memIdx;
  logic aluZero, pcLoad;

  assign rsIdx = irQ[25:21];
  assign rtIdx = irQ[20:16];
  assign rdIdx = irQ[15:11];

  assign rfWrIdx  = strobes.regDst   ? rdIdx : rtIdx;
  assign rfWrData = strobes.memToReg ? mdrQ  : aluOutR;

  mcdp_regfile #(.WIDTH(XLEN), .DEPTH(RF_DEPTH)) u_rf (
    .clk(clk), .rstN(rstN), .wrEn(strobes.regWrite), .wrIdx(rfWrIdx),
    .wrData(rfWrData), .rdIdxA(rsIdx), .rdIdxB(rtIdx),
    .rdDataA(rfA), .rdDataB(rfB)
  );

  assign immExt = {{(XLEN-IMM_W){irQ[IMM_W-1]}}, irQ[IMM_W-1:0]};
  assign opA    = strobes.aluSrcA ? aQ : pcQ;

  always_comb begin
    case (strobes.aluSrcB)
      2'b00:   opB = bQ;
      2'b01:   opB = XLEN'(4);
      2'b10:   opB = immExt;
      default: opB = immExt << 2;
    endcase
  end

  mcdp_alu #(.WIDTH(XLEN)) u_alu (
    .fn(strobes.aluFn), .opA(opA), .opB(opB), .result(aluRes), .isZero(aluZero)
  );

  assign memAddr = strobes.iOrD ? aluOutR : pcQ;
  assign memIdx  = MEM_IDX_W'(memAddr >> 2);

  mcdp_memory #(.WIDTH(XLEN), .WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .rstN(rstN), .wrEn(strobes.memWrite), .wordIdx(memIdx),
    .wrData(bQ), .rdData(memRdData)
  );

  assign jumpTarget = {pcQ[XLEN-1:XLEN-4], irQ[25:0], 2'b00};

  always_comb begin
    case (strobes.pcSource)
      2'b01:   nextPc = aluOutR;
      2'b10:   nextPc = jumpTarget;
      default: nextPc = aluRes;
    endcase
  end

  assign pcLoad = strobes.pcWrite | (strobes.pcWriteCond & aluZero);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ     <= '0;
      irQ     <= '0;
      mdrQ    <= '0;
      aQ      <= '0;
      bQ      <= '0;
      aluOutR <= '0;
    end else begin
      if (pcLoad)           pcQ  <= nextPc;
      if (strobes.irWrite)  irQ  <= memRdData;
      if (strobes.memRead)  mdrQ <= memRdData;
      aQ      <= rfA;
      bQ      <= rfB;
      aluOutR <= aluRes;
    end
  end

  assign opcode  = irQ[31:26];
  assign funct   = irQ[5:0];
  assign zero    = aluZero;
  assign pcOut   = pcQ;
  assign aluOutQ = aluOutR;
endmodule

// File: rtl/mcdp_top.sv
`timescale 1ns/1ps
module mcdp_top
  import mcdp_pkg::*;
#(
  parameter int unsigned MEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regDst,
  input  logic        regWrite,
  input  logic        aluSrcA,
  input  logic [1:0]  aluSrcB,
  input  logic [1:0]  aluOp,
  input  logic        memRead,
  input  logic        memWrite,
  input  logic        memToReg,
  input  logic        iOrD,
  input  logic        irWrite,
  input  logic        pcWrite,
  input  logic        pcWriteCond,
  input  logic [1:0]  pcSource,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero,
  output logic [31:0] pcOut,
  output logic [31:0] aluOutQ
);
  strobes_t strobes;

  mcdp_ctrl u_ctrl (
    .regDst(regDst), .regWrite(regWrite), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB),
    .aluOp(aluOp), .memRead(memRead), .memWrite(memWrite), .memToReg(memToReg),
    .iOrD(iOrD), .irWrite(irWrite), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
    .pcSource(pcSource), .functField(funct), .strobes(strobes)
  );

  mcdp_datapath #(.MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opcode(opcode), .funct(funct),
    .zero(zero), .pcOut(pcOut), .aluOutQ(aluOutQ)
  );
endmodule

// File: rtl/mcdp_checker.sv
`timescale 1ns/1ps
module mcdp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        aluSrcA,
  input logic [1:0]  aluSrcB,
  input logic [1:0]  aluOp,
  input logic        irWrite,
  input logic        pcWrite,
  input logic        pcWriteCond,
  input logic [1:0]  pcSource,
  input logic [5:0]  opcode,
  input logic [5:0]  funct,
  input logic        zero,
  input logic [31:0] pcOut,
  input logic [31:0] aluOutQ
);
  p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!pcWrite && !(pcWriteCond && zero)) |=> $stable(pcOut));

  p_pc_cond_taken_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pcWriteCond && zero && pcSource == 2'b01) |=> (pcOut == $past(aluOutQ)));

  p_pc_from_reg_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && pcSource == 2'b01) |=> (pcOut == $past(aluOutQ)));

  p_jump_shape_r11: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrite && pcSource == 2'b10) |=>
      (pcOut[1:0] == 2'b00 && pcOut[31:28] == $past(pcOut[31:28])));

  p_pc_plus_four_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!aluSrcA && aluSrcB == 2'b01 && aluOp == 2'b00) |=> (aluOutQ == $past(pcOut) + 32'd4));

  p_ir_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !irWrite |=> ($stable(opcode) && $stable(funct)));
endmodule

bind mcdp_top mcdp_checker u_chk (
  .clk(clk), .rstN(rstN), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp),
  .irWrite(irWrite), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .pcSource(pcSource),
  .opcode(opcode), .funct(funct), .zero(zero), .pcOut(pcOut), .aluOutQ(aluOutQ)
);

// File: tb/tb_mcdp_top.sv
`timescale 1ns/1ps
module tb_mcdp_top;
  localparam int WORDS = 64;
  localparam int IDXW  = 6;
  localparam int NVEC  = 32;

  // control word: [15]regDst [14]regWrite [13]aluSrcA [12:11]aluSrcB [10:9]aluOp
  // [8]memRead [7]memWrite [6]memToReg [5]iOrD [4]irWrite [3]pcWrite [2]pcWriteCond [1:0]pcSource
  localparam logic [15:0] PROG [NVEC] = '{
    16'h0918, 16'h1800, 16'h3000, 16'h4000, 16'h0918, 16'h3000, 16'hF000, 16'h0918,
    16'h3120, 16'h4040, 16'h0918, 16'h2400, 16'hE400, 16'h0918, 16'h2E00, 16'h4000,
    16'h00A0, 16'h0918, 16'h2205, 16'h1800, 16'h0918, 16'h2404, 16'h000A, 16'h0918,
    16'h3120, 16'h4040, 16'h080B, 16'h0918, 16'h2400, 16'h2205, 16'h0918, 16'h0918
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic regDst = 0, regWrite = 0, aluSrcA = 0, memRead = 0, memWrite = 0;
  logic memToReg = 0, iOrD = 0, irWrite = 0, pcWrite = 0, pcWriteCond = 0;
  logic [1:0] aluSrcB = 0, aluOp = 0, pcSource = 0;
  logic [5:0] opcode, funct;
  logic zero;
  logic [31:0] pcOut, aluOutQ;

  mcdp_top dut (
    .clk(clk), .rstN(rstN), .regDst(regDst), .regWrite(regWrite), .aluSrcA(aluSrcA),
    .aluSrcB(aluSrcB), .aluOp(aluOp), .memRead(memRead), .memWrite(memWrite),
    .memToReg(memToReg), .iOrD(iOrD), .irWrite(irWrite), .pcWrite(pcWrite),
    .pcWriteCond(pcWriteCond), .pcSource(pcSource), .opcode(opcode), .funct(funct),
    .zero(zero), .pcOut(pcOut), .aluOutQ(aluOutQ)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] mPc, mIr, mMdr, mA, mB, mAlu;
  logic [31:0] mRf [32];
  logic [31:0] mMem [WORDS];

  function automatic logic [31:0] imageWord(input int k);
    logic [5:0] f;
    int r = k % 6;
    f = (r == 0) ? 6'h20 : (r == 1) ? 6'h22 : (r == 2) ? 6'h24 :
        (r == 3) ? 6'h25 : (r == 4) ? 6'h2A : 6'h3F;
    return {6'(k), 5'(k + 16), 5'(k + 1), 5'(k + 17), 5'd0, f};
  endfunction

  function automatic logic [31:0] refAlu(input logic [1:0] op, input logic [5:0] f,
                                         input logic [31:0] x, input logic [31:0] y);
    if (op == 2'b01) return x - y;
    if (op != 2'b10) return x + y;
    case (f)
      6'h20: return x + y;
      6'h22: return x - y;
      6'h24: return x & y;
      6'h25: return x | y;
      6'h2A: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic modelReset();
    mPc = 0; mIr = 0; mMdr = 0; mA = 0; mB = 0; mAlu = 0;
    for (int i = 0; i < 32; i++) mRf[i] = 0;
    for (int k = 0; k < WORDS; k++) mMem[k] = imageWord(k);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    {regDst, regWrite, aluSrcA, aluSrcB, aluOp, memRead, memWrite, memToReg,
     iOrD, irWrite, pcWrite, pcWriteCond, pcSource} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    #1;
    chk("R1 pcOut after reset", pcOut, 32'd0);
    chk("R1 aluOutQ after reset", aluOutQ, 32'd0);
    chk("R1 opcode after reset", {26'd0, opcode}, 32'd0);
    chk("R1 funct after reset", {26'd0, funct}, 32'd0);
  endtask

  // entered and left at a falling edge
  task automatic step(input logic [15:0] v, input string tag);
    logic [31:0] opA, opB, imm, res, addr, rdata, wdata, nextPc, newA, newB;
    logic [4:0] wIdx;
    int idx;
    {regDst, regWrite, aluSrcA, aluSrcB, aluOp, memRead, memWrite, memToReg,
     iOrD, irWrite, pcWrite, pcWriteCond, pcSource} = v;
    #1;
    imm = {{16{mIr[15]}}, mIr[15:0]};
    opA = v[13] ? mA : mPc;
    case (v[12:11])
      2'b00: opB = mB;
      2'b01: opB = 32'd4;
      2'b10: opB = imm;
      default: opB = imm << 2;
    endcase
    res = refAlu(v[10:9], mIr[5:0], opA, opB);
    chk($sformatf("%s zero (R7)", tag), {31'd0, zero}, {31'd0, res == 0});
    addr  = v[5] ? mAlu : mPc;
    idx   = int'(addr[IDXW+1:2]);
    rdata = mMem[idx];
    wIdx  = v[15] ? mIr[15:11] : mIr[20:16];
    wdata = v[6] ? mMdr : mAlu;
    case (v[1:0])
      2'b01: nextPc = mAlu;
      2'b10: nextPc = {mPc[31:28], mIr[25:0], 2'b00};
      default: nextPc = res;
    endcase
    newA = mRf[mIr[25:21]];
    newB = mRf[mIr[20:16]];
    @(posedge clk);
    if (v[3] || (v[2] && res == 0)) mPc = nextPc;
    if (v[4]) mIr = rdata;
    if (v[8]) mMdr = rdata;
    if (v[7]) mMem[idx] = mB;
    if (v[14] && wIdx != 0) mRf[wIdx] = wdata;
    mA = newA;
    mB = newB;
    mAlu = res;
    @(negedge clk);
    chk($sformatf("%s pcOut (R10)", tag), pcOut, mPc);
    chk($sformatf("%s aluOutQ (R6)", tag), aluOutQ, mAlu);
    chk($sformatf("%s opcode (R8)", tag), {26'd0, opcode}, {26'd0, mIr[31:26]});
    chk($sformatf("%s funct (R8)", tag), {26'd0, funct}, {26'd0, mIr[5:0]});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();

    // program walk over the vector table
    for (int i = 0; i < NVEC; i++) step(PROG[i], "table R5 R11 R12");

    // R1: image word 0 fetched: opcode 0, funct 0x20
    doReset();
    step(16'h0918, "R1 R8 fetch");
    chk("R1 boot word 0 funct", {26'd0, funct}, 32'h20);

    // R3: a write to register 0 is ignored, so A + B reads 0
    doReset();
    step(16'h0800, "R3");
    step(16'hC000, "R3");
    step(16'h0000, "R3");
    step(16'h2000, "R3");
    chk("R3 register 0 read back", aluOutQ, 32'd0);

    // R9: store B=4 into word 1, then fetch word 1
    doReset();
    step(16'h0918, "R9");
    step(16'h4000, "R9");
    step(16'h0000, "R9");
    step(16'h00A0, "R9");
    step(16'h0918, "R9 R8");
    chk("R9 stored word as funct", {26'd0, funct}, 32'd4);

    // R2 R4 R12: rt write from ALU result, rd write from data register
    doReset();
    step(16'h0918, "R2 R4 R12");
    step(16'h4000, "R2 R4 R12");
    step(16'hC040, "R2 R4 R12");
    step(16'h0000, "R2 R4 R12");
    chk("R12 PC plus B after rt write", aluOutQ, 32'd8);
    step(16'h0918, "R2 R4 R12");
    step(16'h0000, "R2 R4 R12");
    step(16'h2800, "R2 R4 R12");
    chk("R2 rd register holds image word 0", aluOutQ, imageWord(0) + 32'd4);

    // R5: negative immediate of word 0, plain and shifted
    doReset();
    step(16'h0918, "R5");
    step(16'h1000, "R5");
    chk("R5 sign-extended immediate", aluOutQ, 32'd4 + 32'hFFFF8820);
    step(16'h1800, "R5");
    chk("R5 shifted immediate", aluOutQ, 32'd4 + 32'hFFFE2080);

    // R6 R7: each function code applied to PC and 4
    doReset();
    for (int k = 0; k < 6; k++) begin
      step(16'h0918, "R6 R7");
      step(16'h0C00, "R6 R7");
    end
    step(16'h0A00, "R6 R7 sub");
    step(16'h0E00, "R6 R7 op11");

    // R10 R11: conditional load taken and not taken, jump, source 11
    doReset();
    step(16'h0800, "R10 R11");
    step(16'h0405, "R10 R11 taken");
    chk("R10 conditional load taken", pcOut, 32'd4);
    step(16'h0205, "R10 R11 not taken");
    chk("R10 conditional load held", pcOut, 32'd4);
    step(16'h000A, "R10 R11 jump");
    step(16'h0918, "R10 R11");
    step(16'h000A, "R10 R11 jump");
    chk("R11 jump target", pcOut, {4'd0, imageWord(0)[25:0], 2'b00});
    step(16'h080B, "R10 R11 src11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule